// File: doc/BRIEF.md
# Quad Output Flash Read Engine

This block is the host side of a serial flash read that returns data four bits per clock. Given a start pulse, a byte address, a byte count and an address-width select, it lowers chip select and produces the serial clock from the system clock. It sends the read opcode and then the address one bit at a time on IO0, idles the bus for one dummy byte, and then samples all four IO lines on each clock. Each pair of nibbles becomes one byte, which it presents with a one-cycle valid strobe.

The flash advances its own address after every byte, so one chip-select window carries any number of bytes. A busy flag covers the whole transfer. A one-cycle done pulse marks its end. The address may be 24 bits, which is the default, or 32 bits.

Top module: `qor_engine`

## Requirements
- R1: The opcode 0x6B goes out first on IO0, most significant bit first, one bit per serial clock. IO0 changes only on falling edges, and the serial clock rests low whenever chip select is high.
- R2: The address follows the opcode on IO0, most significant bit first. With `addr4Byte`=0 it is the 24 bits `startAddr[23:0]`, and the upper address bits are never sent. With `addr4Byte`=1 it is all 32 bits of `startAddr`.
- R3: After the last address bit, exactly eight rising clock edges pass before the first data nibble is sampled. A window for N bytes therefore holds exactly 8+A+8+2N rising edges, where A is 24 or 32.
- R4: The host never enables IO1 to IO3. IO0 is enabled only while opcode and address bits are sent, and all four lines are released during the dummy and data clocks.
- R5: Each data byte is rebuilt from two nibbles sampled on rising edges. The first nibble on `ioIn[3:0]` supplies bits 7:4 and the second supplies bits 3:0. Each byte appears on `dataOut` with a one-cycle `dataValid` pulse.
- R6: N bytes are read in one chip-select window and delivered in order, from consecutive flash addresses starting at the start address. In 24-bit mode the address wraps within 24 bits.
- R7: Chip select falls exactly one half clock period before the first rising edge. It rises after the last nibble, together with the clock returning low. `busy` stays high while chip select is low, and `doneFlag` pulses for exactly one cycle when the transfer ends.
- R8: A start request made while `busy` is high is ignored, and the transfer in progress continues unchanged.
- R9: A start with a byte count of zero raises `doneFlag` on the next cycle, leaves chip select high and leaves `busy` low.
- R10: Every high and low phase of the serial clock inside a window lasts exactly `DIV` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Start pulse, taken only when idle |
| startAddr | input | 32 | First byte address |
| byteCount | input | 16 | Number of bytes to read |
| addr4Byte | input | 1 | 1 selects a 32-bit address, 0 selects 24-bit |
| busy | output | 1 | A transfer is in progress |
| doneFlag | output | 1 | One-cycle pulse at the end of a transfer |
| dataOut | output | 8 | Received byte |
| dataValid | output | 1 | One-cycle strobe for dataOut |
| csN | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock, idle low |
| ioOut | output | 4 | Values driven on IO3..IO0 |
| ioOe | output | 4 | Output enables for IO3..IO0 |
| ioIn | input | 4 | Values sampled from IO3..IO0 |

## Verification
The hardest case to reach from the ports is a second start pulse that arrives mid-transfer. The bench raises one during the data phase with a different address and count, then checks three things: only one chip-select window occurs, the flash model latched the first address, and the byte stream matches the first request. A flash model in the bench decodes what is driven on IO0 and answers with bytes computed from the address it latched. Its vectors include a 24-bit read that wraps past 0xFFFFFF and a 24-bit read whose upper start-address bits are non-zero.

// File: rtl/qor_pkg.sv
package qor_pkg;
  localparam logic [7:0] READ_OPCODE  = 8'h6B;
  localparam int         OPC_BITS     = 8;
  localparam int         ADDR_SHORT   = 24;
  localparam int         ADDR_LONG    = 32;
  localparam int         DUMMY_CLKS   = 8;
  localparam int         FRAME_BITS   = OPC_BITS + ADDR_LONG;

  typedef enum logic [1:0] {PH_IDLE, PH_CMD, PH_DUMMY, PH_DATA} phase_t;

  typedef struct packed {
    logic load;
    logic shift;
    logic releaseIo0;
    logic sample;
  } dp_ctl_t;
endpackage

// File: rtl/qor_dpath.sv
module qor_dpath
  import qor_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dp_ctl_t     ctl,
  input  logic [31:0] startAddr,
  input  logic        addr4Byte,
  input  logic [3:0]  ioIn,
  output logic [3:0]  ioOut,
  output logic [3:0]  ioOe,
  output logic [7:0]  dataOut,
  output logic        dataValid
);
  logic [FRAME_BITS-1:0] frameSr;
  logic                  io0En;
  logic [3:0]            hiNib;
  logic                  secondNib;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameSr <= '0;
      io0En   <= 1'b0;
    end else if (ctl.load) begin
      io0En <= 1'b1;
      if (addr4Byte) frameSr <= {READ_OPCODE, startAddr};
      else           frameSr <= {READ_OPCODE, startAddr[ADDR_SHORT-1:0], 8'h00};
    end else if (ctl.shift) begin
      frameSr <= {frameSr[FRAME_BITS-2:0], 1'b0};
    end else if (ctl.releaseIo0) begin
      io0En <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiNib     <= '0;
      secondNib <= 1'b0;
      dataOut   <= '0;
      dataValid <= 1'b0;
    end else begin
      dataValid <= 1'b0;
      if (ctl.load) begin
        secondNib <= 1'b0;
      end else if (ctl.sample) begin
        if (!secondNib) begin
          hiNib     <= ioIn;
          secondNib <= 1'b1;
        end else begin
          dataOut   <= {hiNib, ioIn};
          dataValid <= 1'b1;
          secondNib <= 1'b0;
        end
      end
    end
  end

  assign ioOut = {3'b000, frameSr[FRAME_BITS-1]};
  assign ioOe  = {3'b000, io0En};

  // R4: IO0 must already be released whenever a data nibble is sampled
  p_io0_released_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.sample |-> !io0En);
  // R5: byte strobe is a single-cycle pulse
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);
endmodule

// File: rtl/qor_ctrl.sv
module qor_ctrl
  import qor_pkg::*;
#(
  parameter int DIV   = 2,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CNT_W-1:0] byteCount,
  input  logic             addr4Byte,
  output logic             csN,
  output logic             sclk,
  output logic             busy,
  output logic             doneFlag,
  output dp_ctl_t          ctl
);
  localparam int CW = CNT_W + 1;
  localparam int HW = $clog2(DIV) + 1;
  localparam logic [CW-1:0] CMD_SHORT = CW'(OPC_BITS + ADDR_SHORT);
  localparam logic [CW-1:0] CMD_LONG  = CW'(OPC_BITS + ADDR_LONG);
  localparam logic [CW-1:0] DUMMY_END = CW'(DUMMY_CLKS);

  phase_t        phase;
  logic [HW-1:0] halfCnt;
  logic [CW-1:0] edgeCnt;
  logic [CW-1:0] cmdBits;
  logic [CW-1:0] nibTarget;
  logic          accept, tick, riseNow, fallNow;

  assign busy    = (phase != PH_IDLE);
  assign accept  = startReq && !busy;
  assign tick    = busy && (halfCnt == HW'(DIV - 1));
  assign riseNow = tick && !sclk;
  assign fallNow = tick && sclk;

  always_comb begin
    ctl            = '0;
    ctl.load       = accept && (byteCount != '0);
    ctl.shift      = fallNow && (phase == PH_CMD) && (edgeCnt != cmdBits);
    ctl.releaseIo0 = fallNow && (phase == PH_CMD) && (edgeCnt == cmdBits);
    ctl.sample     = riseNow && (phase == PH_DATA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfCnt <= '0;
    end else if (!busy || tick) begin
      halfCnt <= '0;
    end else begin
      halfCnt <= halfCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      csN       <= 1'b1;
      sclk      <= 1'b0;
      doneFlag  <= 1'b0;
      edgeCnt   <= '0;
      cmdBits   <= CMD_SHORT;
      nibTarget <= '0;
    end else begin
      doneFlag <= 1'b0;
      if (phase == PH_IDLE) begin
        if (accept) begin
          if (byteCount == '0) begin
            doneFlag <= 1'b1;
          end else begin
            phase     <= PH_CMD;
            csN       <= 1'b0;
            edgeCnt   <= '0;
            cmdBits   <= addr4Byte ? CMD_LONG : CMD_SHORT;
            nibTarget <= {byteCount, 1'b0};
          end
        end
      end else if (tick) begin
        sclk <= ~sclk;
        if (riseNow) begin
          edgeCnt <= edgeCnt + 1'b1;
        end else begin
          case (phase)
            PH_CMD: if (edgeCnt == cmdBits) begin
              phase   <= PH_DUMMY;
              edgeCnt <= '0;
            end
            PH_DUMMY: if (edgeCnt == DUMMY_END) begin
              phase   <= PH_DATA;
              edgeCnt <= '0;
            end
            PH_DATA: if (edgeCnt == nibTarget) begin
              phase    <= PH_IDLE;
              csN      <= 1'b1;
              doneFlag <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R1: clock rests low outside the chip-select window
  p_sclk_idle_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);
  // R7: busy covers the whole window
  p_busy_covers_cs_r7: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> busy);
  // R7: completion is a one-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |=> !doneFlag);
  // R9: zero-length request finishes at once without chip select
  p_zero_len_r9: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy && byteCount == '0) |=> (csN && doneFlag));
  // R8: a request while busy does not end or restart the window
  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq && !csN && !tick) |=> !csN);
endmodule

// File: rtl/qor_engine.sv
module qor_engine
  import qor_pkg::*;
#(
  parameter int DIV   = 2,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [31:0]      startAddr,
  input  logic [CNT_W-1:0] byteCount,
  input  logic             addr4Byte,
  output logic             busy,
  output logic             doneFlag,
  output logic [7:0]       dataOut,
  output logic             dataValid,
  output logic             csN,
  output logic             sclk,
  output logic [3:0]       ioOut,
  output logic [3:0]       ioOe,
  input  logic [3:0]       ioIn
);
  dp_ctl_t ctl;

  qor_ctrl #(.DIV(DIV), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .byteCount(byteCount),
    .addr4Byte(addr4Byte), .csN(csN), .sclk(sclk), .busy(busy),
    .doneFlag(doneFlag), .ctl(ctl)
  );

  qor_dpath dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startAddr(startAddr),
    .addr4Byte(addr4Byte), .ioIn(ioIn), .ioOut(ioOut), .ioOe(ioOe),
    .dataOut(dataOut), .dataValid(dataValid)
  );
endmodule

// File: tb/qor_engine_tb.sv
`timescale 1ns/100ps
module qor_engine_tb_top;
  localparam int DIV = 2;

  typedef struct packed {
    logic [31:0] addr;
    logic [7:0]  n;
    logic        mode;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{addr: 32'hAA00_0010, n: 8'd4, mode: 1'b0},
    '{addr: 32'h1234_5678, n: 8'd3, mode: 1'b1},
    '{addr: 32'h00FF_FFFE, n: 8'd4, mode: 1'b0},
    '{addr: 32'h0000_00FF, n: 8'd1, mode: 1'b1},
    '{addr: 32'h0000_ABCD, n: 8'd7, mode: 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [31:0] startAddr = '0;
  logic [15:0] byteCount = '0;
  logic        addr4Byte = 1'b0;
  logic        busy, doneFlag, dataValid, csN, sclk;
  logic [7:0]  dataOut;
  logic [3:0]  ioOut, ioOe;
  logic [3:0]  flashIo = '0;

  int checks = 0, fails = 0, cycles = 0;

  always #2.5 clk = ~clk;

  qor_engine #(.DIV(DIV), .CNT_W(16)) dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startAddr(startAddr),
    .byteCount(byteCount), .addr4Byte(addr4Byte), .busy(busy),
    .doneFlag(doneFlag), .dataOut(dataOut), .dataValid(dataValid),
    .csN(csN), .sclk(sclk), .ioOut(ioOut), .ioOe(ioOe), .ioIn(flashIo)
  );

  function automatic logic [7:0] memByte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h5A;
  endfunction

  // flash model and port monitors, all evaluated away from the active edge
  int          pe = 0, csFalls = 0, leadCnt = 0, highRun = 0, lowRun = 0;
  int          oeErr = 0, halfErr = 0, busyErr = 0, doneHigh = 0, midEdge = 0;
  int          cmdBitsTb = 32, gotN = 0;
  logic        prevSclk = 1'b0, prevCs = 1'b1;
  logic [39:0] capt = '0;
  logic [7:0]  got [16];

  function automatic logic [31:0] latchedAddr();
    return (cmdBitsTb == 40) ? capt[31:0] : {8'h00, capt[23:0]};
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (!csN && prevCs) begin pe = 0; csFalls++; leadCnt = 0; lowRun = 0; end
    if (doneFlag) doneHigh++;
    if (dataValid && gotN < 16) begin got[gotN] = dataOut; gotN++; end
    if (ioOe[3:1] != 3'b000) oeErr++;
    if (!csN && !busy) busyErr++;
    if (csN && sclk) halfErr++;
    if (!csN && pe == 0 && !sclk) leadCnt++;
    if (sclk) highRun++;
    else if (highRun != 0) begin
      if (highRun != DIV) halfErr++;
      highRun = 0;
    end
    if (!csN && !sclk && pe > 0) lowRun++;
    if (sclk && !prevSclk && !csN) begin
      if (pe > 0 && lowRun != DIV) halfErr++;
      lowRun = 0;
      if (pe < cmdBitsTb) begin
        if (!ioOe[0]) oeErr++;
        capt = {capt[38:0], ioOut[0]};
      end else if (ioOe[0]) oeErr++;
      pe++;
    end
    if (!sclk && prevSclk && !csN && pe >= cmdBitsTb + 8) begin
      automatic int n = pe - (cmdBitsTb + 8);
      automatic logic [31:0] a = latchedAddr() + 32'(n / 2);
      automatic logic [7:0] b;
      if (cmdBitsTb != 40) a[31:24] = 8'h00;
      b = memByte(a);
      flashIo = (n % 2 == 0) ? b[7:4] : b[3:0];
    end
    if (!sclk && prevSclk && !csN && pe > 0 && pe < cmdBitsTb) midEdge++;
    prevSclk = sclk;
    prevCs   = csN;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic startXfer(input logic [31:0] a, input logic [15:0] n, input logic m);
    @(negedge clk);
    startAddr = a; byteCount = n; addr4Byte = m; startReq = 1'b1;
    cmdBitsTb = m ? 40 : 32;
    gotN = 0; doneHigh = 0; csFalls = 0; oeErr = 0; halfErr = 0; busyErr = 0;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic waitDone();
    for (int k = 0; k < 20000 && !doneFlag; k++) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic checkXfer(input logic [31:0] a, input int n, input logic m);
    automatic logic [31:0] expA = m ? a : {8'h00, a[23:0]};
    automatic logic [7:0] expOp = (cmdBitsTb == 40) ? capt[39:32] : capt[31:24];
    automatic int bad = 0;
    chk(expOp == 8'h6B, "R1 opcode", expOp, 8'h6B);
    chk(latchedAddr() == expA, "R2 address", latchedAddr(), expA);
    chk(pe == cmdBitsTb + 8 + 2 * n, "R3 rising edges", pe, cmdBitsTb + 8 + 2 * n);
    chk(oeErr == 0, "R4 enables", oeErr, 0);
    chk(gotN == n, "R6 byte count", gotN, n);
    for (int i = 0; i < n && i < 16; i++) begin
      automatic logic [31:0] ea = expA + 32'(i);
      if (!m) ea[31:24] = 8'h00;
      if (got[i] != memByte(ea)) begin
        bad++;
        chk(1'b0, "R5 byte value", got[i], memByte(ea));
      end
    end
    chk(bad == 0, "R6 stream order", bad, 0);
    chk(csFalls == 1, "R6 single window", csFalls, 1);
    chk(leadCnt == DIV, "R7 cs lead", leadCnt, DIV);
    chk(busyErr == 0 && doneHigh == 1 && csN, "R7 busy/done", doneHigh, 1);
    chk(halfErr == 0, "R10 half period", halfErr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(csN == 1'b1 && sclk == 1'b0, "R1 reset idle bus", {csN, sclk}, 2'b10);
    chk(ioOe == 4'h0 && !busy && !doneFlag && !dataValid, "R4 reset outputs",
        {ioOe, busy, doneFlag, dataValid}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // vector table
    for (int v = 0; v < 5; v++) begin
      startXfer(VECS[v].addr, 16'(VECS[v].n), VECS[v].mode);
      waitDone();
      checkXfer(VECS[v].addr, int'(VECS[v].n), VECS[v].mode);
    end

    // R8: second request during data phase must be ignored
    startXfer(32'h0000_3000, 16'd5, 1'b0);
    while (pe < cmdBitsTb + 12) @(negedge clk);
    startAddr = 32'h0000_7777; byteCount = 16'd2; addr4Byte = 1'b1; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    startAddr = 32'h0000_3000; byteCount = 16'd5; addr4Byte = 1'b0;
    waitDone();
    checkXfer(32'h0000_3000, 5, 1'b0);
    chk(csFalls == 1 && gotN == 5, "R8 busy start ignored", gotN, 5);

    // R9: zero-length request
    @(negedge clk);
    startAddr = 32'h0000_0040; byteCount = 16'd0; addr4Byte = 1'b0; startReq = 1'b1;
    csFalls = 0;
    @(negedge clk);
    startReq = 1'b0;
    chk(doneFlag && csN && !busy, "R9 zero count done", {doneFlag, csN, busy}, 3'b110);
    @(negedge clk);
    chk(!doneFlag && csN && csFalls == 0, "R9 zero count no window",
        {doneFlag, csN}, 2'b01);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule